// File: doc/BRIEF.md
# Selectable-Order Sinc Decimation Filter

This block turns the single-bit stream of an oversampling sigma-delta modulator into signed multi-bit conversion words at a reduced rate. Each accepted input bit stands for +1 or -1, so the ones density encodes the analog level. A cascaded integrator-comb structure does the filtering. Its integrators advance at the modulator rate and its combs at the output rate. One output word is produced for every M accepted bits. The notch of the response sits at the output rate, so choosing M so that this rate equals the mains frequency rejects mains pickup.

The filter order can be selected while the block runs. First order gives the plain M-sample sum and settles within one output period. Third order is the cube of that boxcar and needs three periods to settle. Changing the order or the ratio wipes all filter state. The valid strobe is then held back until the new configuration has settled.

Top module: `sinc_decimator`

## Requirements
- R1: While `rst_n` is low and after its release, `out_valid` is 0 and `out_word` is 0 until the first decimation.
- R2: An accepted bit of 1 counts as +1 and a bit of 0 counts as -1. In first order with ratio M, a stream of all ones gives +M and a stream of all zeros gives -M.
- R3: The sample counter counts only samples with `in_valid` high. The accepted sample that completes a group of M raises `out_valid` for exactly one cycle, in the cycle after that sample is clocked in.
- R4: With `sinc3_sel`=0 (first order), each word is the sum of the last M mapped samples. `out_valid` is given from the first period after a clear.
- R5: With `sinc3_sel`=1 (third order), each word is the last mapped samples convolved with three cascaded length-M boxcars (3M-2 taps). The gain is M^3.
- R6: In third order, the first two decimations after a clear produce no `out_valid`. The third and all later decimations do.
- R7: Cycles with `in_valid` low leave the filter state and the sample count untouched. The results are identical to the same samples sent without gaps.
- R8: A change of `sinc3_sel` or of the effective ratio clears all integrator and comb state, the sample count and the settling count. The sample offered in that cycle is dropped, and `out_valid` is 0 in the following cycle.
- R9: `dec_ratio` values 0 and 1 act as a ratio of 2. Valid ratios are 2 to `M_MAX`.
- R10: At ratio `M_MAX` a third-order full-scale input gives exactly ±`M_MAX`^3 with no wraparound. No valid word ever has a magnitude above `M_MAX`^3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifies `in_bit` as a modulator sample |
| in_bit | input | 1 | Modulator output bit |
| sinc3_sel | input | 1 | 0 selects first order, 1 selects third order |
| dec_ratio | input | $clog2(M_MAX+1) | Decimation ratio M |
| out_word | output | 3*$clog2(M_MAX)+2 | Signed conversion result |
| out_valid | output | 1 | One-cycle strobe for a settled result |

## Verification
A word is due exactly one clock after the accepted sample that completes a group of M. The bench drives on the falling edge and checks on the next falling edge. It keeps its own count of accepted samples, so it knows in which cycle a strobe must appear and in which cycle none may. The withheld strobes of the settling period are checked in those same cycles. Expected words come from a direct convolution of the recorded stream with a kernel built in the bench. A configuration change is given one idle cycle, and the bench checks there that the strobe stays low.

// File: rtl/sinc_decimator.sv
module sinc_decimator #(
  parameter int M_MAX = 64,
  localparam int RW = $clog2(M_MAX + 1),
  localparam int AW = 3 * $clog2(M_MAX) + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 in_bit,
  input  logic                 sinc3_sel,
  input  logic [RW-1:0]        dec_ratio,
  output logic signed [AW-1:0] out_word,
  output logic                 out_valid
);

  logic [RW-1:0] m_eff, m_q, cnt;
  logic          sel_q, cfg_chg, dec, settled;
  logic [1:0]    settle_cnt;
  logic signed [AW-1:0] x, i1, i2, i3, i1n, i2n, i3n;
  logic signed [AW-1:0] d1, d3a, d3b, d3c, c1, ca, cb, cc;

  assign m_eff   = (dec_ratio < RW'(2)) ? RW'(2) : dec_ratio;
  assign cfg_chg = (sinc3_sel != sel_q) || (m_eff != m_q);
  assign dec     = in_valid && !cfg_chg && (cnt == m_q - RW'(1));
  assign settled = sel_q ? (settle_cnt >= 2'd2) : 1'b1;

  assign x   = in_bit ? AW'(1) : '1;
  assign i1n = i1 + x;
  assign i2n = i2 + i1n;
  assign i3n = i3 + i2n;

  assign c1 = i1n - d1;
  assign ca = i3n - d3a;
  assign cb = ca - d3b;
  assign cc = cb - d3c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q      <= 1'b0;
      m_q        <= RW'(2);
      cnt        <= '0;
      settle_cnt <= '0;
      i1 <= '0; i2 <= '0; i3 <= '0;
      d1 <= '0; d3a <= '0; d3b <= '0; d3c <= '0;
      out_word   <= '0;
      out_valid  <= 1'b0;
    end else if (cfg_chg) begin
      sel_q      <= sinc3_sel;
      m_q        <= m_eff;
      cnt        <= '0;
      settle_cnt <= '0;
      i1 <= '0; i2 <= '0; i3 <= '0;
      d1 <= '0; d3a <= '0; d3b <= '0; d3c <= '0;
      out_word   <= '0;
      out_valid  <= 1'b0;
    end else begin
      out_valid <= dec && settled;
      if (in_valid) begin
        i1  <= i1n;
        i2  <= i2n;
        i3  <= i3n;
        cnt <= dec ? '0 : cnt + RW'(1);
      end
      if (dec) begin
        d1  <= i1n;
        d3a <= i3n;
        d3b <= ca;
        d3c <= cb;
        out_word <= sel_q ? cc : c1;
        if (settle_cnt != 2'd3) settle_cnt <= settle_cnt + 2'd1;
      end
    end
  end

endmodule

module sinc_decimator_chk #(
  parameter int M_MAX = 64,
  localparam int RW = $clog2(M_MAX + 1),
  localparam int AW = 3 * $clog2(M_MAX) + 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 sinc3_sel,
  input logic [RW-1:0]        dec_ratio,
  input logic signed [AW-1:0] out_word,
  input logic                 out_valid
);

  localparam longint LIM = longint'(M_MAX) * longint'(M_MAX) * longint'(M_MAX);

  // R3
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R3
  strobe_after_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  // R8
  mode_change_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sinc3_sel != $past(sinc3_sel)) |=> !out_valid);

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (longint'(out_word) <= LIM && longint'(out_word) >= -LIM));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && out_word == '0));

  // R9
  ratio_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(dec_ratio));

endmodule

bind sinc_decimator sinc_decimator_chk #(.M_MAX(M_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sinc3_sel(sinc3_sel),
  .dec_ratio(dec_ratio), .out_word(out_word), .out_valid(out_valid)
);

// File: tb/tb_sinc_decimator.sv
`timescale 1ns/1ps
module tb_sinc_decimator;
  localparam int M_MAX = 64;
  localparam int RW = $clog2(M_MAX + 1);
  localparam int AW = 3 * $clog2(M_MAX) + 2;

  logic clk = 0, rst_n = 0, in_valid = 0, in_bit = 0, sinc3_sel = 0;
  logic [RW-1:0] dec_ratio = RW'(2);
  logic signed [AW-1:0] out_word;
  logic out_valid;

  int errors = 0, checks = 0;
  bit done = 0;
  int hist[0:8191];
  int h[0:255];
  int hlen, n;

  always #2.5 clk = ~clk;

  sinc_decimator #(.M_MAX(M_MAX)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
    .sinc3_sel(sinc3_sel), .dec_ratio(dec_ratio),
    .out_word(out_word), .out_valid(out_valid));

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit pat_bit(int pat, int i);
    case (pat)
      0: return 1'b1;
      1: return 1'b0;
      2: return i[0];
      default: return ((i * 7 + i / 5) % 11) < 7;
    endcase
  endfunction

  task automatic build_kernel(bit sel, int m);
    if (!sel) begin
      hlen = m;
      for (int j = 0; j < m; j++) h[j] = 1;
    end else begin
      hlen = 3 * m - 2;
      for (int j = 0; j < hlen; j++) begin
        h[j] = 0;
        for (int a = 0; a < m; a++)
          for (int b = 0; b < m; b++)
            if (j - a - b >= 0 && j - a - b < m) h[j]++;
      end
    end
  endtask

  function automatic longint model();
    longint s = 0;
    for (int j = 0; j < hlen; j++)
      if (n - 1 - j >= 0) s += longint'(h[j]) * longint'(hist[n - 1 - j]);
    return s;
  endfunction

  task automatic do_reset();
    in_valid = 0;
    rst_n = 0;
    repeat (2) @(negedge clk);
    chk(out_valid == 0 && out_word == 0, "R1 reset state", out_valid, 0);
    rst_n = 1;
    @(negedge clk);
    chk(out_valid == 0 && out_word == 0, "R1 after release", out_word, 0);
  endtask

  task automatic run(bit rst, bit sel, int mcfg, int mmod, int pat, int nper,
                     bit gaps, string tag);
    bit expect_dec = 0;
    int cyc = 0;
    if (rst) do_reset();
    @(negedge clk);
    in_valid = 0;
    sinc3_sel = sel;
    dec_ratio = RW'(mcfg);
    @(negedge clk);
    chk(out_valid == 0, {tag, " R8 quiet on config"}, out_valid, 0);
    build_kernel(sel, mmod);
    n = 0;
    forever begin
      if (expect_dec) begin
        int per = n / mmod;
        bit ev = per >= (sel ? 3 : 1);
        chk(out_valid == ev, {tag, (sel ? " R6" : " R4"), " strobe"}, out_valid, ev);
        if (ev) begin
          longint got = longint'(out_word);
          longint e = model();
          chk(got == e, {tag, " value"}, got, e);
        end
      end else begin
        chk(out_valid == 0, {tag, " R3 no strobe mid-period"}, out_valid, 0);
      end
      expect_dec = 0;
      if (n >= nper * mmod) break;
      if (gaps && (cyc % 3 == 2)) begin
        in_valid = 0;
        in_bit = ~in_bit;
      end else begin
        bit b = pat_bit(pat, n);
        in_valid = 1;
        in_bit = b;
        hist[n] = b ? 1 : -1;
        n++;
        if (n % mmod == 0) expect_dec = 1;
      end
      cyc++;
      @(negedge clk);
    end
    in_valid = 0;
  endtask

  task automatic t_full_scale_sinc1();
    run(1, 0, 8, 8, 0, 2, 0, "R2 ones sinc1");
    chk(longint'(out_word) == 8, "R2 +M", out_word, 8);
    run(1, 0, 16, 16, 1, 2, 0, "R2 zeros sinc1");
    chk(longint'(out_word) == -16, "R2 -M", out_word, -16);
  endtask

  task automatic t_sinc3_basic();
    run(1, 1, 4, 4, 0, 4, 0, "R5 ones sinc3");
    chk(longint'(out_word) == 64, "R5 gain M^3", out_word, 64);
    run(1, 1, 5, 5, 2, 5, 0, "R5 alternating sinc3");
    run(1, 1, 16, 16, 3, 5, 0, "R5 mixed sinc3");
  endtask

  task automatic t_gaps();
    run(1, 0, 7, 7, 3, 4, 1, "R7 gaps sinc1");
    run(1, 1, 6, 6, 3, 5, 1, "R7 gaps sinc3");
  endtask

  task automatic t_reconfig();
    run(1, 1, 8, 8, 3, 4, 0, "R8 before change");
    run(0, 0, 8, 8, 3, 3, 0, "R8 mode to sinc1");
    run(0, 1, 8, 8, 2, 4, 0, "R8 mode to sinc3");
    run(0, 1, 6, 6, 3, 4, 0, "R8 ratio change");
  endtask

  task automatic t_small_ratio();
    run(1, 0, 0, 2, 3, 6, 0, "R9 ratio 0");
    run(0, 1, 1, 2, 3, 6, 0, "R9 ratio 1");
  endtask

  task automatic t_max_ratio();
    run(1, 1, M_MAX, M_MAX, 0, 3, 0, "R10 max ones");
    chk(longint'(out_word) == longint'(M_MAX) ** 3, "R10 +max", out_word,
        longint'(M_MAX) ** 3);
    run(1, 1, M_MAX, M_MAX, 1, 3, 0, "R10 max zeros");
    chk(longint'(out_word) == -(longint'(M_MAX) ** 3), "R10 -max", out_word,
        -(longint'(M_MAX) ** 3));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog R3 actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    t_full_scale_sinc1();
    t_sinc3_basic();
    t_gaps();
    t_reconfig();
    t_small_ratio();
    t_max_ratio();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule